// File: doc/BRIEF.md
# Dirty Scanline Run Coalescer

This block turns a per-line "modified since the last snapshot" indication into a short list of rectangular repaint requests. Once a frame is started with its line count, the block takes one dirty flag per line over a valid/ready handshake, lines 0 through count minus 1 in order. Adjacent dirty lines are merged into one run, and each run leaves as a single record with a first line and a number of lines. A record always covers the whole width of the display from column 0, so it carries no horizontal fields.

A run that is still open on the last line of the frame is flushed with the remaining line count. When the frame is started with a full-repaint request, for example after a change of video mode, the block takes no dirty flags and emits a single record that covers the whole frame. The output record stream has its own valid/ready handshake. Backpressure on it holds the line scan, so no run is lost. A one-cycle done pulse marks the end of every frame, including frames that produce no records.

Top module: `dirty_run_coalescer`

## Requirements
- R1: After reset, upd_valid_o, line_ready_o and done_o are all 0, and the block waits for start_i.
- R2: A run begins at a dirty line (line_dirty_i = 1) that arrives while no run is open. It ends at the next clean line (line_dirty_i = 0). It is emitted with upd_y_o equal to its first line and upd_h_o equal to the clean line's index minus that first line.
- R3: A run still open when the last line (index lines_i - 1) is accepted is emitted with upd_h_o equal to lines_i minus its first line. This includes a run that consists of the last line alone.
- R4: Lines are taken strictly in ascending order, one per cycle in which line_valid_i and line_ready_o are both 1. Exactly lines_i lines are taken per scanned frame. A record held on the output while upd_ready_i is 0 keeps its values, and no line is taken while a record is waiting.
- R5: If full_i is 1 when start_i is accepted and lines_i is nonzero, no line is taken and exactly one record (upd_y_o = 0, upd_h_o = lines_i) is emitted.
- R6: done_o is high for exactly one cycle per frame, after the last record of that frame has been accepted. A frame with no dirty lines emits no record and still raises done_o.
- R7: A frame started with lines_i = 0 emits no record and raises done_o.
- R8: start_i, lines_i and full_i are ignored while a frame is in progress.
- R9: Every emitted record has upd_h_o of at least 1, and upd_y_o + upd_h_o does not exceed the frame's line count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a frame (taken only when idle) |
| lines_i | input | LINE_W | Number of lines in the frame |
| full_i | input | 1 | Emit one whole-frame record instead of scanning |
| line_valid_i | input | 1 | A dirty flag is offered |
| line_dirty_i | input | 1 | 1 if the offered line was modified |
| line_ready_o | output | 1 | The block takes the offered flag this cycle |
| upd_valid_o | output | 1 | A repaint record is available |
| upd_ready_i | input | 1 | The consumer takes the record this cycle |
| upd_y_o | output | LINE_W | First line of the record |
| upd_h_o | output | LINE_W | Number of lines in the record |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench builds the block with LINE_W = 7. A 6-line frame then has only 64 possible dirty patterns, and the bench runs every one of them under four combinations of input gaps and output stalls. This exercises every run position, every run length and every end-of-frame flush. Further frames cover a single line, an empty frame, a 64-line frame with its extreme patterns, full-repaint requests and a restart attempt in the middle of a frame.

// File: rtl/drc_pkg.sv
package drc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FULL = 2'd2,
        ST_FIN  = 2'd3
    } drc_state_e;
endpackage

// File: rtl/drc_run_tracker.sv
// Decides, for one accepted line, whether a run opens, closes or flushes.
module drc_run_tracker #(
    parameter int LINE_W = 12
) (
    input  logic              dirty,
    input  logic              last,
    input  logic              open_q,
    input  logic [LINE_W-1:0] start_q,
    input  logic [LINE_W-1:0] cur,
    input  logic [LINE_W-1:0] lines,
    output logic              open_d,
    output logic [LINE_W-1:0] start_d,
    output logic              emit,
    output logic [LINE_W-1:0] emit_y,
    output logic [LINE_W-1:0] emit_h
);
    always_comb begin
        open_d  = open_q;
        start_d = start_q;
        emit    = 1'b0;
        emit_y  = start_q;
        emit_h  = '0;
        if (dirty && !open_q) begin
            open_d  = 1'b1;
            start_d = cur;
        end
        if (!dirty && open_q) begin
            emit   = 1'b1;
            emit_y = start_q;
            emit_h = cur - start_q;
            open_d = 1'b0;
        end
        if (last) begin
            open_d = 1'b0;
            if (dirty) begin
                emit   = 1'b1;
                emit_y = open_q ? start_q : cur;
                emit_h = lines - (open_q ? start_q : cur);
            end
        end
    end
endmodule

// File: rtl/drc_out_slot.sv
// Single-entry holding register for outgoing records.
module drc_out_slot #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LINE_W-1:0] load_y,
    input  logic [LINE_W-1:0] load_h,
    input  logic              ready,
    output logic              valid,
    output logic [LINE_W-1:0] y,
    output logic [LINE_W-1:0] h
);
    typedef struct packed {
        logic              v;
        logic [LINE_W-1:0] y;
        logic [LINE_W-1:0] h;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.v && ready) begin
            slot_d.v = 1'b0;
        end
        if (load) begin
            slot_d.v = 1'b1;
            slot_d.y = load_y;
            slot_d.h = load_h;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign valid = slot_q.v;
    assign y     = slot_q.y;
    assign h     = slot_q.h;
endmodule

// File: rtl/dirty_run_coalescer.sv
module dirty_run_coalescer #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LINE_W-1:0] lines_i,
    input  logic              full_i,
    input  logic              line_valid_i,
    input  logic              line_dirty_i,
    output logic              line_ready_o,
    output logic              upd_valid_o,
    input  logic              upd_ready_i,
    output logic [LINE_W-1:0] upd_y_o,
    output logic [LINE_W-1:0] upd_h_o,
    output logic              done_o
);
    import drc_pkg::*;

    localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

    typedef struct packed {
        drc_state_e        st;
        logic [LINE_W-1:0] cur;
        logic [LINE_W-1:0] lines;
        logic [LINE_W-1:0] start;
        logic              open;
        logic              done;
    } ctl_t;

    ctl_t q, d;

    logic              out_valid;
    logic              load;
    logic [LINE_W-1:0] load_y, load_h;
    logic              line_acc, is_last;
    logic              trk_open, trk_emit;
    logic [LINE_W-1:0] trk_start, trk_y, trk_h;
    logic [LINE_W-1:0] lines_cur;

    assign line_ready_o = (q.st == ST_SCAN) && !out_valid;
    assign line_acc     = line_valid_i && line_ready_o;
    assign is_last      = (q.cur == (q.lines - ONE));
    assign lines_cur    = q.lines;

    drc_run_tracker #(.LINE_W(LINE_W)) u_trk (
        .dirty   (line_dirty_i),
        .last    (is_last),
        .open_q  (q.open),
        .start_q (q.start),
        .cur     (q.cur),
        .lines   (q.lines),
        .open_d  (trk_open),
        .start_d (trk_start),
        .emit    (trk_emit),
        .emit_y  (trk_y),
        .emit_h  (trk_h)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        load   = 1'b0;
        load_y = '0;
        load_h = '0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.lines = lines_i;
                    d.cur   = '0;
                    d.start = '0;
                    d.open  = 1'b0;
                    if (lines_i == '0) begin
                        d.st = ST_FIN;
                    end else if (full_i) begin
                        d.st = ST_FULL;
                    end else begin
                        d.st = ST_SCAN;
                    end
                end
            end
            ST_FULL: begin
                if (!out_valid) begin
                    load   = 1'b1;
                    load_y = '0;
                    load_h = q.lines;
                    d.st   = ST_FIN;
                end
            end
            ST_SCAN: begin
                if (line_acc) begin
                    d.open  = trk_open;
                    d.start = trk_start;
                    load    = trk_emit;
                    load_y  = trk_y;
                    load_h  = trk_h;
                    if (is_last) begin
                        d.st = ST_FIN;
                    end else begin
                        d.cur = q.cur + ONE;
                    end
                end
            end
            ST_FIN: begin
                if (!out_valid) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.cur   <= '0;
            q.lines <= '0;
            q.start <= '0;
            q.open  <= 1'b0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    drc_out_slot #(.LINE_W(LINE_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .load_y (load_y),
        .load_h (load_h),
        .ready  (upd_ready_i),
        .valid  (out_valid),
        .y      (upd_y_o),
        .h      (upd_h_o)
    );

    assign upd_valid_o = out_valid;
    assign done_o      = q.done;
endmodule

// File: rtl/drc_checker.sv
module drc_checker #(
    parameter int LINE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_valid_o,
    input logic              upd_ready_i,
    input logic [LINE_W-1:0] upd_y_o,
    input logic [LINE_W-1:0] upd_h_o,
    input logic              line_ready_o,
    input logic              done_o,
    input logic [LINE_W-1:0] lines_cur
);
    // R4: a stalled record keeps its values
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_o && !upd_ready_i) |=> (upd_valid_o && $stable(upd_y_o) && $stable(upd_h_o)));

    // R4: no line is taken while a record waits
    a_r4_no_line_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        line_ready_o |-> !upd_valid_o);

    // R6: done lasts one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: done only once the output is drained
    a_r6_done_drained: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!upd_valid_o && !line_ready_o));

    // R9: records are non-empty
    a_r9_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_o |-> (upd_h_o != '0));

    // R9: records stay inside the frame
    a_r9_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_o |-> (({1'b0, upd_y_o} + {1'b0, upd_h_o}) <= {1'b0, lines_cur}));
endmodule

bind dirty_run_coalescer drc_checker #(.LINE_W(LINE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_valid_o  (upd_valid_o),
    .upd_ready_i  (upd_ready_i),
    .upd_y_o      (upd_y_o),
    .upd_h_o      (upd_h_o),
    .line_ready_o (line_ready_o),
    .done_o       (done_o),
    .lines_cur    (lines_cur)
);

// File: tb/tb_dirty_run_coalescer.sv
module tb_dirty_run_coalescer;
    localparam int LINE_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [LINE_W-1:0] lines_i = '0;
    logic              full_i = 1'b0;
    logic              line_valid_i = 1'b0;
    logic              line_dirty_i = 1'b0;
    logic              line_ready_o;
    logic              upd_valid_o;
    logic              upd_ready_i = 1'b0;
    logic [LINE_W-1:0] upd_y_o;
    logic [LINE_W-1:0] upd_h_o;
    logic              done_o;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_y[64];
    int exp_h[64];
    int exp_n;
    int got_y[64];
    int got_h[64];
    int got_n;

    always #4 clk = ~clk;

    dirty_run_coalescer #(.LINE_W(LINE_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .lines_i(lines_i),
        .full_i(full_i), .line_valid_i(line_valid_i), .line_dirty_i(line_dirty_i),
        .line_ready_o(line_ready_o), .upd_valid_o(upd_valid_o),
        .upd_ready_i(upd_ready_i), .upd_y_o(upd_y_o), .upd_h_o(upd_h_o),
        .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model(input int n, input logic [63:0] pat, input bit full);
        bit open = 1'b0;
        int s = 0;
        exp_n = 0;
        if (n == 0) return;
        if (full) begin
            exp_y[0] = 0; exp_h[0] = n; exp_n = 1;
            return;
        end
        for (int i = 0; i < n; i++) begin
            if (pat[i] && !open) begin
                open = 1'b1; s = i;
            end else if (!pat[i] && open) begin
                exp_y[exp_n] = s; exp_h[exp_n] = i - s; exp_n++;
                open = 1'b0;
            end
        end
        if (open) begin
            exp_y[exp_n] = s; exp_h[exp_n] = n - s; exp_n++;
        end
    endtask

    task automatic run_frame(input int n, input logic [63:0] pat, input bit full,
                             input int mode, input bit restart_mid);
        int idx = 0;
        int taken = 0;
        bit seen_done = 1'b0;
        model(n, pat, full);
        got_n = 0;
        @(negedge clk);
        start_i = 1'b1; lines_i = LINE_W'(n); full_i = full;
        @(negedge clk);
        start_i = 1'b0; full_i = 1'b0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            if (restart_mid && cyc == 3) begin
                start_i = 1'b1; full_i = 1'b1; lines_i = LINE_W'(5);
            end else begin
                start_i = 1'b0; full_i = 1'b0;
            end
            upd_ready_i = (mode == 0) || (cyc % (mode + 1) == 0);
            if (idx < n) begin
                line_valid_i = (mode < 2) || (cyc % 2 == 0);
                line_dirty_i = pat[idx];
            end else begin
                line_valid_i = 1'b0;
                line_dirty_i = 1'b0;
            end
            if (line_valid_i && line_ready_o) begin
                idx++; taken++;
            end
            if (upd_valid_o && upd_ready_i && got_n < 64) begin
                got_y[got_n] = int'(upd_y_o);
                got_h[got_n] = int'(upd_h_o);
                got_n++;
            end
            if (done_o) begin
                seen_done = 1'b1;
                break;
            end
            @(negedge clk);
        end
        start_i = 1'b0; full_i = 1'b0; line_valid_i = 1'b0;
        chk(seen_done, "R6", "done seen", int'(seen_done), 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R6", "done width", int'(done_o), 0);
        chk(got_n == exp_n, (n == 0) ? "R7" : (full ? "R5" : "R2"),
            "record count", got_n, exp_n);
        chk(taken == ((full || n == 0) ? 0 : n), full ? "R5" : "R4",
            "lines taken", taken, (full || n == 0) ? 0 : n);
        for (int k = 0; k < exp_n && k < got_n; k++) begin
            chk(got_y[k] == exp_y[k], full ? "R5" : "R2", "record y", got_y[k], exp_y[k]);
            chk(got_h[k] == exp_h[k],
                full ? "R5" : ((exp_y[k] + exp_h[k] == n) ? "R3" : "R2"),
                "record h", got_h[k], exp_h[k]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(upd_valid_o == 1'b0, "R1", "reset upd_valid", int'(upd_valid_o), 0);
        chk(line_ready_o == 1'b0, "R1", "reset line_ready", int'(line_ready_o), 0);
        chk(done_o == 1'b0, "R1", "reset done", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_ready_o == 1'b0, "R1", "idle line_ready", int'(line_ready_o), 0);

        // R2 R3 R4: every 6-line pattern under four stall modes
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 64; p++) begin
                run_frame(6, 64'(p), 1'b0, m, 1'b0);
            end
        end
        // R3: single-line frames
        run_frame(1, 64'h0, 1'b0, 0, 1'b0);
        run_frame(1, 64'h1, 1'b0, 2, 1'b0);
        // R7: empty frame
        run_frame(0, 64'h0, 1'b0, 0, 1'b0);
        run_frame(0, 64'h0, 1'b1, 0, 1'b0);
        // R6: clean 64-line frame, R2 R3 wide patterns
        run_frame(64, 64'h0, 1'b0, 1, 1'b0);
        run_frame(64, {64{1'b1}}, 1'b0, 3, 1'b0);
        run_frame(64, 64'hAAAA_5555_F0F0_0FF1, 1'b0, 2, 1'b0);
        // R5: full repaint
        run_frame(6, 64'h3F, 1'b1, 0, 1'b0);
        run_frame(64, 64'h5, 1'b1, 3, 1'b0);
        // R8: restart attempts during a frame are ignored
        run_frame(12, 64'hC36, 1'b0, 0, 1'b1);
        run_frame(20, 64'h0, 1'b1, 3, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule